// File: doc/BRIEF.md
# Width-Converting Dual-Clock FIFO

This block carries data between two unrelated clock domains and halves the word width on the way. The producer pushes 32-bit words on its own clock. The consumer pops 16-bit half-words on a second clock. Each stored word comes out as two half-words: the low half first, then the high half. The read side sees the head half-word on `rd_data` whenever `empty` is low, so reading works as first-word fall-through.

Each domain keeps a binary pointer for addressing and a Gray-coded copy for crossing. The write pointer counts 32-bit entries. The read pointer counts half-words, so it is one bit wider. Its entry part (all bits except the lowest) is Gray encoded and sent to the write side. Each Gray pointer passes through a chain of flip-flops in the far domain, and the chain length is a parameter. `full` and `empty` are registered flags. Each one compares a local pointer with a lagging copy of the far pointer, so a flag can be released late but is never released early. Each domain also has its own reset synchronizer, so reset asserts at once and is released on that domain's clock.

Top module: `cdc_fifo_32to16`

## Requirements
- R1: While either reset is held, and after both resets are released, `empty` is 1 and `full` is 0 until the first write.
- R2: Each stored 32-bit word leaves as two half-words: bits [15:0] first, then bits [31:16].
- R3: Words leave in the order in which they were written, across several words and across wrap of the storage address.
- R4: After 2^ADDR_W writes with no entry freed, `full` is 1 from the wclk edge that accepted the last write. A write while `full` is 1 is ignored: the word is never read out, and the write pointer does not move.
- R5: A read request while `empty` is 1 is ignored: the read pointer does not move, and the next word written is still read out complete, low half first.
- R6: An entry is freed only when its upper half is read. Reading only the low half of the oldest entry leaves `full` at 1.
- R7: The Gray pointers change by exactly one bit on each update, in both domains.
- R8: `empty` returns to 1 after the last stored half-word has been read. `full` returns to 0 once the read of an upper half has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low. Asserts asynchronously; its release is synchronized to wclk |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Word to store |
| full | output | 1 | Storage full, in the wclk domain |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low. Asserts asynchronously; its release is synchronized to rclk |
| rd_en | input | 1 | Read request; pops the half-word currently on rd_data |
| rd_data | output | WR_W/2 | Head half-word, valid while empty is 0 |
| empty | output | 1 | No half-word available, in the rclk domain |

## Verification
A corrupted write pointer, or a lost half-select bit on the read side, shows up at `rd_data` as a swapped half or a skipped or repeated word. This appears on the very next pop after the fault. A wrong entry conversion, or a wrong full comparison, shows as `full` taken at the wrong count or released after only the low half was read. That becomes visible a few wclk cycles after the read, once the synchronizer delay has passed. Writes while full and reads while empty are checked by what comes out afterwards, since an illegal pointer move corrupts the order of all later data.

// File: rtl/cdc_fifo_32to16.sv
module cdc_fifo_32to16 #(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WR_W        = 32
) (
  input  logic            wclk,
  input  logic            wrst_n,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic            full,
  input  logic            rclk,
  input  logic            rrst_n,
  input  logic            rd_en,
  output logic [WR_W/2-1:0] rd_data,
  output logic            empty
);
  localparam int RD_W  = WR_W / 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [WR_W-1:0] mem [DEPTH];

  logic [1:0] wrst_q, rrst_q;
  logic       w_rst_n, r_rst_n;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) wrst_q <= '0;
    else         wrst_q <= {wrst_q[0], 1'b1};

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) rrst_q <= '0;
    else         rrst_q <= {rrst_q[0], 1'b1};

  assign w_rst_n = wrst_q[1];
  assign r_rst_n = rrst_q[1];

  logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx;
  logic [PW-1:0] r2w [SYNC_STAGES];
  logic [PW-1:0] rsync;
  logic          wr_go;

  assign wr_go    = wr_en & ~full;
  assign wbin_nx  = wbin + PW'(wr_go);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign rsync    = r2w[SYNC_STAGES-1];

  always_ff @(posedge wclk or negedge w_rst_n)
    if (!w_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == {~rsync[PW-1:PW-2], rsync[PW-3:0]});
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[ADDR_W-1:0]] <= wr_data;

  logic [PW:0]   rbin, rbin_nx;
  logic [PW-1:0] rent_nx, rgray, rgray_nx;
  logic [PW-1:0] w2r [SYNC_STAGES];
  logic [PW-1:0] wsync;
  logic          rd_go;
  logic [WR_W-1:0] head;

  assign rd_go    = rd_en & ~empty;
  assign rbin_nx  = rbin + (PW+1)'(rd_go);
  assign rent_nx  = rbin_nx[PW:1];
  assign rgray_nx = (rent_nx >> 1) ^ rent_nx;
  assign wsync    = w2r[SYNC_STAGES-1];

  always_ff @(posedge rclk or negedge r_rst_n)
    if (!r_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wsync);
    end

  assign head    = mem[rbin[ADDR_W:1]];
  assign rd_data = rbin[0] ? head[WR_W-1:RD_W] : head[RD_W-1:0];

  always_ff @(posedge wclk or negedge w_rst_n)
    if (!w_rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) r2w[i] <= '0;
    end else begin
      r2w[0] <= rgray;
      for (int i = 1; i < SYNC_STAGES; i++) r2w[i] <= r2w[i-1];
    end

  always_ff @(posedge rclk or negedge r_rst_n)
    if (!r_rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) w2r[i] <= '0;
    end else begin
      w2r[0] <= wgray;
      for (int i = 1; i < SYNC_STAGES; i++) w2r[i] <= w2r[i-1];
    end
endmodule

module cdc_fifo_32to16_chk #(parameter int PW = 4) (
  input logic          wclk,
  input logic          w_rst_n,
  input logic          wr_en,
  input logic          full,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic          rclk,
  input logic          r_rst_n,
  input logic          rd_en,
  input logic          empty,
  input logic [PW:0]   rbin,
  input logic [PW-1:0] rgray
);
  assert_write_blocked_R4: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (wr_en && full) |=> $stable(wbin));

  assert_read_blocked_R5: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (rd_en && empty) |=> $stable(rbin));

  assert_wgray_one_bit_R7: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (wgray != $past(wgray)) |-> ($countones(wgray ^ $past(wgray)) == 1));

  assert_rgray_one_bit_R7: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (rgray != $past(rgray)) |-> ($countones(rgray ^ $past(rgray)) == 1));

  assert_low_half_keeps_entry_R6: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (rd_en && !empty && !rbin[0]) |=> $stable(rgray));

  assert_reset_flags_R1: assert property (@(posedge wclk) !w_rst_n |-> !full);
endmodule

bind cdc_fifo_32to16 cdc_fifo_32to16_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .w_rst_n(w_rst_n), .wr_en(wr_en), .full(full),
  .wbin(wbin), .wgray(wgray),
  .rclk(rclk), .r_rst_n(r_rst_n), .rd_en(rd_en), .empty(empty),
  .rbin(rbin), .rgray(rgray)
);

// File: tb/test_cdc_fifo_32to16.sv
module test_cdc_fifo_32to16;
  logic        wclk = 0, rclk = 0;
  logic        wrst_n = 0, rrst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        full, empty;
  int checks = 0, fails = 0;

  localparam logic [31:0] VEC [8] = '{
    32'hA1B2_C3D4, 32'h0000_FFFF, 32'hFFFF_0000, 32'h1357_9BDF,
    32'h8001_7FFE, 32'hCAFE_F00D, 32'h0F0F_F0F0, 32'h5A5A_A5A5};

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  cdc_fifo_32to16 i_cdc_fifo_32to16 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge wclk); wr_en = 1; wr_data = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic pop_check(input logic [15:0] exp, input string req);
    int n = 0;
    @(negedge rclk);
    while (empty && n < 50) begin @(negedge rclk); n++; end
    chk(!empty, req, {31'd0, empty}, 32'd0);
    chk(rd_data === exp, req, {16'd0, rd_data}, {16'd0, exp});
    rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #10;
    chk(empty === 1'b1 && full === 1'b0, "R1 in reset", {30'd0, full, empty}, 32'd1);
    #10 wrst_n = 1; rrst_n = 1;
    repeat (10) @(negedge rclk);
    chk(empty === 1'b1 && full === 1'b0, "R1 after reset", {30'd0, full, empty}, 32'd1);

    // fill from the vector table (R4)
    for (int i = 0; i < 8; i++) begin
      push(VEC[i]);
      chk(full === (i == 7), "R4 full at depth", {31'd0, full}, {31'd0, i == 7});
    end
    push(32'hDEAD_BEEF);
    chk(full === 1'b1, "R4 full held", {31'd0, full}, 32'd1);

    // low half only: entry not freed (R6)
    pop_check(VEC[0][15:0], "R2 low half first");
    repeat (12) @(negedge wclk);
    chk(full === 1'b1, "R6 full after low half", {31'd0, full}, 32'd1);
    pop_check(VEC[0][31:16], "R2 high half second");
    repeat (12) @(negedge wclk);
    chk(full === 1'b0, "R8 full released", {31'd0, full}, 32'd0);

    for (int i = 1; i < 8; i++) begin
      pop_check(VEC[i][15:0], "R3 order low");
      pop_check(VEC[i][31:16], "R3 order high");
    end
    repeat (3) @(negedge rclk);
    chk(empty === 1'b1, "R8 empty after drain", {31'd0, empty}, 32'd1);
    repeat (12) @(negedge rclk);
    chk(empty === 1'b1, "R4 dropped word absent", {16'd0, rd_data}, 32'd0);

    // read requests while empty (R5)
    @(negedge rclk); rd_en = 1;
    repeat (5) @(negedge rclk);
    rd_en = 0;
    push(32'h1234_5678);
    pop_check(16'h5678, "R5 low after empty reads");
    pop_check(16'h1234, "R5 high after empty reads");

    // wrap of storage address (R3)
    for (int i = 0; i < 6; i++) push(VEC[7-i] ^ 32'h0101_0101);
    for (int i = 0; i < 6; i++) begin
      pop_check(VEC[7-i][15:0] ^ 16'h0101, "R3 wrap low");
      pop_check(VEC[7-i][31:16] ^ 16'h0101, "R3 wrap high");
    end
    repeat (3) @(negedge rclk);
    chk(empty === 1'b1 && full === 1'b0, "R8 idle after wrap", {30'd0, full, empty}, 32'd1);
    // R7 Gray single-bit steps are covered by the bound checker

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule